// File: doc/BRIEF.md
# Parallel Array Logic-in-Memory ALU

This block is a rectangular grid of processing cells. Each cell keeps four 16-bit words, in planes named A, B, C and T, and every cell executes the same command in the same cycle. A dyadic command combines an operand plane with plane B and writes the result into a destination plane. A direction bit chooses which pair: A with B into C, or C with B into A. Every written dyadic result is also copied into the temporary plane T. A monadic command inverts every bit of one chosen plane.

Software-side agents load and inspect the grid one row at a time. A row write carries one word per column into one plane. A combinational row read returns one plane's row. Division is unsigned. A cell whose B word is zero leaves its destination and T untouched and raises its own error flag. The grid is parameterised; the full-size arrangement is 32x32, and the default build is 4x4.

Top module: `cell_alu_array`

## Requirements
- R1: After reset, every word of all four planes is zero, every error flag is low, and `done` and `busy` are low.
- R2: A row write updates the plane chosen by `hostPlane` (0=A, 1=B, 2=C, 3=T) at row `hostRow` at the next clock edge. Column j takes bits [16j+15:16j] of `hostData`. `rdData` shows the row `rdRow` of plane `rdPlane`, with the same encoding and column layout.
- R3: A `start` sampled at a clock edge makes `busy` high for the following cycle. Results and a one-cycle `done` pulse appear after the next edge. A `start` seen while `busy` is high is ignored.
- R4: With `dirCA`=0, a dyadic result goes to C and to T. With `dirCA`=1, it goes to A and to T. Plane B and the remaining operand plane are unchanged.
- R5: Opcode 0 adds, opcode 1 subtracts (operand minus B), and opcode 2 multiplies. Each keeps the low 16 bits of the exact result.
- R6: Opcode 4 is bitwise OR and opcode 5 is bitwise AND of the operand and B.
- R7: Opcodes 6, 7 and 8 compare the operand with B as unsigned numbers, testing less-than, equal and greater-than in that order. The destination receives 1 when the test is true and 0 otherwise.
- R8: Opcode 3 writes the truncated unsigned quotient of operand divided by B in every cell where B is nonzero.
- R9: In a cell whose B is zero, opcode 3 leaves the destination and T unchanged and sets that cell's error flag (bit row*COLS+col of `errFlags`). Every executed command rewrites each flag, so any command other than a faulting divide clears it.
- R10: Opcode 9 inverts every bit of the plane chosen by `monoSel` (0=A, 1=B, 2=C, 3=T) in every cell. The other planes are unchanged.
- R11: A row write presented in the cycle where `busy` is high has no effect.
- R12: Opcodes 10 to 15 change no plane. They still produce `done` and clear the error flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Command strobe |
| opCode | input | 4 | Command code |
| dirCA | input | 1 | Result direction: 0 gives A,B to C; 1 gives C,B to A |
| monoSel | input | 2 | Plane targeted by the complement |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | High in the execution cycle |
| hostWr | input | 1 | Row write enable |
| hostPlane | input | 2 | Plane for the row write |
| hostRow | input | $clog2(ROWS) | Row for the row write |
| hostData | input | COLS*16 | Row write data |
| rdPlane | input | 2 | Plane for the row read |
| rdRow | input | $clog2(ROWS) | Row for the row read |
| rdData | output | COLS*16 | Row read data |
| errFlags | output | ROWS*COLS | Per-cell divide-by-zero flags |

## Verification
Two functions can fall in the same cycle: a row write and the execution of a command. The bench presents a row write into plane B while `busy` is high. It then reads the row back and expects the old contents, and checks that the command's own results are still correct. A second collision holds `start` across the execution cycle. This is judged by a single `done` pulse and by a direction-1 add that must be applied exactly once.

// File: rtl/cell_alu_pkg.sv
package cell_alu_pkg;
  typedef enum logic [3:0] {
    OP_ADD = 4'd0, OP_SUB = 4'd1, OP_MUL = 4'd2, OP_DIV = 4'd3,
    OP_OR  = 4'd4, OP_AND = 4'd5, OP_LT  = 4'd6, OP_EQ  = 4'd7,
    OP_GT  = 4'd8, OP_NOT = 4'd9
  } op_e;

  typedef enum logic [1:0] {PL_A = 2'd0, PL_B = 2'd1, PL_C = 2'd2, PL_T = 2'd3} plane_e;

  typedef struct packed {
    logic       exec;
    logic [3:0] op;
    logic       dir;
    logic [1:0] monoPlane;
  } cmd_s;
endpackage

// File: rtl/cell_alu_ctrl.sv
module cell_alu_ctrl
  import cell_alu_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [3:0] opCode,
  input  logic       dirCA,
  input  logic [1:0] monoSel,
  output cmd_s       cmd,
  output logic       done,
  output logic       busy
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmd  <= '0;
      done <= 1'b0;
    end else begin
      done <= cmd.exec;
      if (start && !cmd.exec)
        cmd <= '{exec: 1'b1, op: opCode, dir: dirCA, monoPlane: monoSel};
      else
        cmd.exec <= 1'b0;
    end
  end

  assign busy = cmd.exec;

  // R3: an execution cycle is always followed by done
  a_r3_done_follows: assert property (@(posedge clk) disable iff (!rstN)
    cmd.exec |=> done);
  // R3: a start during the execution cycle is not accepted
  a_r3_exec_single: assert property (@(posedge clk) disable iff (!rstN)
    cmd.exec |=> !cmd.exec);
  a_r3_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
endmodule

// File: rtl/cell_alu_cell.sv
module cell_alu_cell
  import cell_alu_pkg::*;
#(
  parameter int WW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  cmd_s          cmd,
  input  logic          hostWr,
  input  logic [1:0]    hostPlane,
  input  logic [WW-1:0] hostData,
  output logic [WW-1:0] regA,
  output logic [WW-1:0] regB,
  output logic [WW-1:0] regC,
  output logic [WW-1:0] regT,
  output logic          divErr
);
  logic [WW-1:0]   srcWord;
  logic [WW-1:0]   result;
  logic [2*WW-1:0] product;
  logic            bZero;
  logic            isDyadic;
  logic            writeRes;

  assign srcWord  = cmd.dir ? regC : regA;
  assign bZero    = (regB == '0);
  assign product  = srcWord * regB;
  assign isDyadic = (cmd.op <= OP_GT);

  always_comb begin
    result = '0;
    case (cmd.op)
      OP_ADD:  result = srcWord + regB;
      OP_SUB:  result = srcWord - regB;
      OP_MUL:  result = product[WW-1:0];
      OP_DIV:  result = bZero ? '0 : srcWord / regB;
      OP_OR:   result = srcWord | regB;
      OP_AND:  result = srcWord & regB;
      OP_LT:   result = WW'(srcWord < regB);
      OP_EQ:   result = WW'(srcWord == regB);
      OP_GT:   result = WW'(srcWord > regB);
      default: result = '0;
    endcase
  end

  assign writeRes = isDyadic && !(cmd.op == OP_DIV && bZero);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regA   <= '0;
      regB   <= '0;
      regC   <= '0;
      regT   <= '0;
      divErr <= 1'b0;
    end else if (cmd.exec) begin
      divErr <= (cmd.op == OP_DIV) && bZero;
      if (writeRes) begin
        if (cmd.dir) regA <= result;
        else         regC <= result;
        regT <= result;
      end else if (cmd.op == OP_NOT) begin
        case (cmd.monoPlane)
          PL_A:    regA <= ~regA;
          PL_B:    regB <= ~regB;
          PL_C:    regC <= ~regC;
          default: regT <= ~regT;
        endcase
      end
    end else if (hostWr) begin
      case (hostPlane)
        PL_A:    regA <= hostData;
        PL_B:    regB <= hostData;
        PL_C:    regC <= hostData;
        default: regT <= hostData;
      endcase
    end
  end

  // R9: divide by zero keeps destination and T, raises the flag
  a_r9_div_zero_keeps: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.exec && cmd.op == OP_DIV && bZero) |=>
      ($stable(regA) && $stable(regC) && $stable(regT) && divErr));
  // R7: comparison results are boolean words
  a_r7_cmp_boolean: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.exec && cmd.op >= OP_LT && cmd.op <= OP_GT) |=>
      (($past(cmd.dir) ? regA : regC) <= WW'(1)));
  // R4: dyadic commands never touch B
  a_r4_b_untouched: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.exec && cmd.op != OP_NOT) |=> $stable(regB));
  // R11, R12: unused opcodes and blocked writes leave every plane alone
  a_r12_unused_op_idle: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.exec && cmd.op > OP_NOT) |=>
      ($stable(regA) && $stable(regB) && $stable(regC) && $stable(regT) && !divErr));
endmodule

// File: rtl/cell_alu_grid.sv
module cell_alu_grid
  import cell_alu_pkg::*;
#(
  parameter int ROWS = 4,
  parameter int COLS = 4,
  parameter int WW   = 16,
  localparam int RW  = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  cmd_s               cmd,
  input  logic               hostWr,
  input  logic [1:0]         hostPlane,
  input  logic [RW-1:0]      hostRow,
  input  logic [COLS*WW-1:0] hostData,
  input  logic [1:0]         rdPlane,
  input  logic [RW-1:0]      rdRow,
  output logic [COLS*WW-1:0] rdData,
  output logic [ROWS*COLS-1:0] errFlags
);
  logic [WW-1:0] planeA [ROWS][COLS];
  logic [WW-1:0] planeB [ROWS][COLS];
  logic [WW-1:0] planeC [ROWS][COLS];
  logic [WW-1:0] planeT [ROWS][COLS];

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      cell_alu_cell #(.WW(WW)) i_cell (
        .clk      (clk),
        .rstN     (rstN),
        .cmd      (cmd),
        .hostWr   (hostWr && (hostRow == RW'(r))),
        .hostPlane(hostPlane),
        .hostData (hostData[c*WW +: WW]),
        .regA     (planeA[r][c]),
        .regB     (planeB[r][c]),
        .regC     (planeC[r][c]),
        .regT     (planeT[r][c]),
        .divErr   (errFlags[r*COLS + c])
      );
    end
  end

  always_comb begin
    rdData = '0;
    if (int'(rdRow) < ROWS) begin
      for (int c = 0; c < COLS; c++) begin
        case (rdPlane)
          PL_A:    rdData[c*WW +: WW] = planeA[rdRow][c];
          PL_B:    rdData[c*WW +: WW] = planeB[rdRow][c];
          PL_C:    rdData[c*WW +: WW] = planeC[rdRow][c];
          default: rdData[c*WW +: WW] = planeT[rdRow][c];
        endcase
      end
    end
  end
endmodule

// File: rtl/cell_alu_array.sv
module cell_alu_array
  import cell_alu_pkg::*;
#(
  parameter int ROWS = 4,
  parameter int COLS = 4,
  parameter int WW   = 16,
  localparam int RW  = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 start,
  input  logic [3:0]           opCode,
  input  logic                 dirCA,
  input  logic [1:0]           monoSel,
  output logic                 done,
  output logic                 busy,
  input  logic                 hostWr,
  input  logic [1:0]           hostPlane,
  input  logic [RW-1:0]        hostRow,
  input  logic [COLS*WW-1:0]   hostData,
  input  logic [1:0]           rdPlane,
  input  logic [RW-1:0]        rdRow,
  output logic [COLS*WW-1:0]   rdData,
  output logic [ROWS*COLS-1:0] errFlags
);
  cmd_s cmd;

  cell_alu_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .opCode(opCode),
    .dirCA(dirCA), .monoSel(monoSel), .cmd(cmd), .done(done), .busy(busy)
  );

  cell_alu_grid #(.ROWS(ROWS), .COLS(COLS), .WW(WW)) i_grid (
    .clk(clk), .rstN(rstN), .cmd(cmd), .hostWr(hostWr), .hostPlane(hostPlane),
    .hostRow(hostRow), .hostData(hostData), .rdPlane(rdPlane), .rdRow(rdRow),
    .rdData(rdData), .errFlags(errFlags)
  );
endmodule

// File: tb/test_cell_alu_array.sv
module test_cell_alu_array;
  localparam int ROWS = 4;
  localparam int COLS = 4;
  localparam int WW   = 16;
  localparam int RW   = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [3:0] opCode = '0;
  logic dirCA = 1'b0;
  logic [1:0] monoSel = '0;
  logic done, busy;
  logic hostWr = 1'b0;
  logic [1:0] hostPlane = '0;
  logic [RW-1:0] hostRow = '0;
  logic [COLS*WW-1:0] hostData = '0;
  logic [1:0] rdPlane = '0;
  logic [RW-1:0] rdRow = '0;
  logic [COLS*WW-1:0] rdData;
  logic [ROWS*COLS-1:0] errFlags;

  int nTests = 0;
  int nFail = 0;

  logic [WW-1:0] mdl [4][ROWS][COLS];
  logic [ROWS*COLS-1:0] mErr = '0;

  always #10 clk = ~clk;

  cell_alu_array #(.ROWS(ROWS), .COLS(COLS), .WW(WW)) i_cell_alu_array (
    .clk(clk), .rstN(rstN), .start(start), .opCode(opCode), .dirCA(dirCA),
    .monoSel(monoSel), .done(done), .busy(busy), .hostWr(hostWr),
    .hostPlane(hostPlane), .hostRow(hostRow), .hostData(hostData),
    .rdPlane(rdPlane), .rdRow(rdRow), .rdData(rdData), .errFlags(errFlags)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [WW-1:0] pat(int s, int p, int r, int c);
    int k = r*COLS + c;
    if (s == 0) begin
      if (p == 0) return 16'hFFFF;
      if (p == 2) return 16'h7FFF;
      case (k % 4)
        0: return 16'h0000;
        1: return 16'h0001;
        2: return 16'hFFFF;
        default: return 16'h8000;
      endcase
    end
    if (p == 1 && ((k + s) % 5 == 0)) return 16'h0000;
    return 16'((s*40503 + p*12345 + k*4099) ^ (k << (s % 7)));
  endfunction

  function automatic logic [WW-1:0] refOp(int op, logic [WW-1:0] x, logic [WW-1:0] y);
    logic [31:0] prod;
    prod = x * y;
    case (op)
      0: return x + y;
      1: return x - y;
      2: return prod[15:0];
      3: return x / y;
      4: return x | y;
      5: return x & y;
      6: return (x < y) ? 16'd1 : 16'd0;
      7: return (x == y) ? 16'd1 : 16'd0;
      default: return (x > y) ? 16'd1 : 16'd0;
    endcase
  endfunction

  task automatic writeRow(int p, int r, logic [COLS*WW-1:0] d);
    @(negedge clk);
    hostWr = 1'b1; hostPlane = 2'(p); hostRow = RW'(r); hostData = d;
    @(negedge clk);
    hostWr = 1'b0;
  endtask

  task automatic loadAll(int s);
    for (int p = 0; p < 4; p++)
      for (int r = 0; r < ROWS; r++) begin
        logic [COLS*WW-1:0] d;
        for (int c = 0; c < COLS; c++) begin
          d[c*WW +: WW] = pat(s, p, r, c);
          mdl[p][r][c] = pat(s, p, r, c);
        end
        writeRow(p, r, d);
      end
  endtask

  task automatic checkAll(string req);
    for (int p = 0; p < 4; p++)
      for (int r = 0; r < ROWS; r++) begin
        logic [COLS*WW-1:0] e;
        for (int c = 0; c < COLS; c++) e[c*WW +: WW] = mdl[p][r][c];
        rdPlane = 2'(p); rdRow = RW'(r);
        #1;
        chk(rdData === e, $sformatf("%s plane%0d row%0d", req, p, r), rdData, e);
      end
    chk(errFlags === mErr, $sformatf("%s R9 flags", req), 64'(errFlags), 64'(mErr));
  endtask

  task automatic applyModel(int op, bit dir, int sel);
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) begin
        logic [WW-1:0] x, y, res;
        x = dir ? mdl[2][r][c] : mdl[0][r][c];
        y = mdl[1][r][c];
        mErr[r*COLS+c] = (op == 3) && (y == 0);
        if (op <= 8 && !(op == 3 && y == 0)) begin
          res = refOp(op, x, y);
          if (dir) mdl[0][r][c] = res; else mdl[2][r][c] = res;
          mdl[3][r][c] = res;
        end else if (op == 9) begin
          mdl[sel][r][c] = ~mdl[sel][r][c];
        end
      end
  endtask

  task automatic runOp(int op, bit dir, int sel, bit holdStart, bit busyWr);
    @(negedge clk);
    opCode = 4'(op); dirCA = dir; monoSel = 2'(sel); start = 1'b1;
    @(negedge clk);
    if (!holdStart) start = 1'b0;
    chk(busy === 1'b1 && done === 1'b0, "R3 busy cycle", {busy, done}, 2'b10);
    if (busyWr) begin
      hostWr = 1'b1; hostPlane = 2'd1; hostRow = '0; hostData = 64'h1234_5678_9ABC_DEF0;
    end
    @(negedge clk);
    start = 1'b0; hostWr = 1'b0;
    chk(done === 1'b1 && busy === 1'b0, "R3 done pulse", {busy, done}, 2'b01);
    applyModel(op, dir, sel);
    @(negedge clk);
    chk(done === 1'b0, "R3 done single", done, 1'b0);
  endtask

  function automatic string opReq(int op);
    if (op <= 2) return "R5";
    if (op == 3) return "R8";
    if (op <= 5) return "R6";
    return "R7";
  endfunction

  initial begin
    #(20ns * 200000);
    nTests++; nFail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    for (int p = 0; p < 4; p++)
      for (int r = 0; r < ROWS; r++)
        for (int c = 0; c < COLS; c++) mdl[p][r][c] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(done === 1'b0 && busy === 1'b0, "R1 strobes", {busy, done}, 2'b00);
    checkAll("R1");

    // R2 row load and read-back on every plane
    loadAll(1);
    checkAll("R2");

    // dyadic sweep over patterns, opcodes and both directions (R4..R9)
    for (int s = 0; s < 3; s++) begin
      loadAll(s);
      for (int op = 0; op <= 8; op++)
        for (int d = 0; d < 2; d++) begin
          runOp(op, d[0], 0, 1'b0, 1'b0);
          checkAll($sformatf("%s%s", opReq(op), d ? " R4" : ""));
        end
    end

    // R9: a faulting divide then a clearing add
    loadAll(0);
    runOp(3, 1'b0, 0, 1'b0, 1'b0);
    checkAll("R9 set");
    runOp(0, 1'b0, 0, 1'b0, 1'b0);
    checkAll("R9 clear");

    // R10 complement on each plane
    loadAll(2);
    for (int sel = 0; sel < 4; sel++) begin
      runOp(9, 1'b0, sel, 1'b0, 1'b0);
      checkAll("R10");
    end

    // R12 unused opcodes after a faulting divide
    loadAll(0);
    runOp(3, 1'b1, 0, 1'b0, 1'b0);
    for (int op = 10; op < 16; op++) begin
      runOp(op, 1'b0, 0, 1'b0, 1'b0);
      checkAll("R12");
    end

    // R11 row write colliding with execution
    loadAll(3);
    runOp(0, 1'b0, 0, 1'b0, 1'b1);
    checkAll("R11");

    // R3 start held through the execution cycle: applied once
    runOp(0, 1'b1, 0, 1'b1, 1'b0);
    checkAll("R3 held start");

    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule